// File: doc/BRIEF.md
# I2C register-file target

This block is an I2C target that lets a bus master read and write a 256-entry byte register file held outside the block. It samples SCL and SDA on a faster system clock, finds START, repeated START and STOP conditions, matches one fixed 7-bit device address, and pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

Every access goes through an 8-bit register pointer that lives inside the block. The pointer is kept across STOP and across idle time. A master can therefore set it once and then read again later without sending it a second time. The first byte after a write-direction address always loads the pointer. Each data byte moved in either direction advances the pointer, and the pointer wraps from 0xFF to 0x00.

The register file is attached through a plain port. `reg_addr` always shows the pointer. `reg_wdata` comes with a one-cycle `reg_we` strobe. `reg_rdata` must return the byte at `reg_addr` combinationally.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges (SDA low on the 9th clock) only the address byte whose upper seven bits equal 0x39. For any other address it leaves SDA released for the whole transaction, writes nothing and leaves the pointer unchanged until the next START or STOP.
- R2: After a matched address with direction bit 0, the first byte is loaded into the pointer and acknowledged.
- R3: Each later byte in a write transaction is acknowledged, written to the register at the pointer with a single-cycle `reg_we` strobe, and the pointer then increments.
- R4: A read after a repeated START (address with direction bit 1, preceded by a pointer-setting write) returns bytes MSB first, starting at the pointer just set and advancing by one per byte.
- R5: A read that starts directly with START and the address with direction bit 1 continues from the retained pointer, including after a STOP.
- R6: A master NACK on a read byte makes the block release SDA and stop sending; the pointer is left at the last byte read plus one.
- R7: The pointer wraps from 0xFF to 0x00 on both reads and writes.
- R8: The block changes its SDA drive only while SCL is low.
- R9: A STOP or START that arrives in the middle of a byte abandons that byte: nothing is written, and a START begins a new address phase.
- R10: After reset, SDA is released, `reg_we` is low and the pointer (`reg_addr`) is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Register pointer, address of the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The register write strobe and the start of the ACK drive are both produced on the same SCL falling edge, in the same system cycle, that follows the eighth data bit. The pointer increment comes out of that same strobe. The bench sets this up by writing all 256 locations in one transaction and by writing across the 0xFF boundary. It judges the result by the ACK the master samples on the ninth clock and by reading the stored bytes back in later transactions, where a wrong pointer shows up as data taken from the wrong location.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sr[SYNC_STAGES-1];
      sda_d  <= sda_sr[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int AW = 8,
  parameter logic [AW-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= RESET_VAL;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic rw, mack, ptr_ld, rd_inc;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_reg_ptr #(.AW(BYTE_W), .RESET_VAL('0)) u_ptr (
    .clk(clk), .rst(rst), .ld(ptr_ld), .ld_val(sh),
    .inc(reg_we | rd_inc), .ptr(reg_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      mack      <= 1'b1;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      ptr_ld    <= 1'b0;
      rd_inc    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      ptr_ld <= 1'b0;
      rd_inc <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  st     <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end else if (st == ST_PTR) begin
                sda_oe <= 1'b1;
                ptr_ld <= 1'b1;
                st     <= ST_PTR_ACK;
              end else begin
                sda_oe    <= 1'b1;
                reg_we    <= 1'b1;
                reg_wdata <= sh;
                st        <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                sh     <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                rd_inc <= 1'b1;
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~sh[BYTE_W-2];
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= sda_s;
            end else if (scl_fall) begin
              if (!mack) begin
                sh     <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RDATA;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       rd_inc,
  input logic       ptr_ld,
  input tgt_state_e st
);
  assert_sda_low_phase_R8: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_wr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (reg_addr == 8'($past(reg_addr) + 8'd1)));

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_rd_advance_R4: assert property (@(posedge clk) disable iff (rst)
    rd_inc |=> (reg_addr == 8'($past(reg_addr) + 8'd1)));

  assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> (!sda_oe && !reg_we));

  assert_ignore_ptr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |=> $stable(reg_addr));

  assert_ptr_load_acked_R2: assert property (@(posedge clk) disable iff (rst)
    ptr_ld |-> sda_oe);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .rd_inc(rd_inc), .ptr_ld(ptr_ld), .st(st)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we, sda_bus;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int checks = 0, errs = 0, exp_ptr = 0, r8_bad = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  always @(posedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl === 1'b1) r8_bad++;
    oe_prev <= sda_oe;
  end

  i2c_regfile_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ 8'h5A);
  endfunction

  task automatic qd();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qd(); scl = 1'b1; qd(); sda_m = 1'b0; qd(); scl = 1'b0; qd();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qd(); scl = 1'b1; qd(); sda_m = 1'b1; qd();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qd(); scl = 1'b1; qd(); qd(); scl = 1'b0; qd();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qd(); scl = 1'b1; qd(); b = sda_bus; qd(); scl = 1'b0; qd();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      get_byte(k == n - 1, d);
      chk(tag, d, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 256;
    end
    chk("R6 released after master NACK", sda_oe, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    logic ack;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    qd();
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset reg_we", reg_we, 0);
    chk("R10 reset pointer", reg_addr, 0);

    // full write sweep from pointer 0x00, wraps back to 0x00
    i2c_start();
    send_byte(8'h72, ack); chk("R1 address ACK", ack, 0);
    send_byte(8'h00, ack); chk("R2 pointer ACK", ack, 0);
    for (int a = 0; a < 256; a++) begin
      send_byte(pat(a), ack);
      chk("R3 data ACK", ack, 0);
      exp_mem[a] = pat(a);
    end
    i2c_stop();
    exp_ptr = 0;
    chk("R7 pointer wrapped after write", reg_addr, 0);

    // pointerless read from retained pointer
    i2c_start();
    send_byte(8'h73, ack); chk("R5 read address ACK", ack, 0);
    read_seq(4, "R5 pointerless read data");
    i2c_stop();

    // pointer-set read with repeated START, crossing 0xFF
    i2c_start();
    send_byte(8'h72, ack); chk("R4 address ACK", ack, 0);
    send_byte(8'hFC, ack); chk("R4 pointer ACK", ack, 0);
    i2c_start();
    send_byte(8'h73, ack); chk("R4 restart read ACK", ack, 0);
    exp_ptr = 8'hFC;
    read_seq(8, "R4 R7 pointer-set read wrap");
    i2c_stop();

    i2c_start();
    send_byte(8'h73, ack); chk("R5 ACK after stop", ack, 0);
    read_seq(2, "R5 read continues after STOP");
    i2c_stop();

    // address sweep: every other address is refused
    for (int a = 0; a < 128; a++) begin
      if (a != 7'h39) begin
        i2c_start();
        send_byte({7'(a), 1'b1}, ack);
        chk("R1 foreign address NACK", ack, 1);
        i2c_stop();
      end
    end
    i2c_start();
    send_byte(8'h44, ack); chk("R1 foreign write NACK", ack, 1);
    send_byte(8'h00, ack); chk("R1 ignored pointer byte", ack, 1);
    send_byte(8'hAA, ack); chk("R1 ignored data byte", ack, 1);
    i2c_stop();
    chk("R1 pointer unchanged", reg_addr, exp_ptr);
    i2c_start();
    send_byte(8'h73, ack); chk("R1 ACK after sweep", ack, 0);
    read_seq(1, "R1 memory and pointer unchanged");
    i2c_stop();

    // abort by STOP in the middle of a data byte
    i2c_start();
    send_byte(8'h72, ack);
    send_byte(8'h40, ack); chk("R9 pointer ACK", ack, 0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    exp_ptr = 8'h40;
    i2c_start();
    send_byte(8'h73, ack);
    read_seq(1, "R9 no write after STOP abort");
    i2c_stop();

    // abort by repeated START in the middle of a data byte
    i2c_start();
    send_byte(8'h72, ack);
    send_byte(8'h50, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    i2c_start();
    send_byte(8'h73, ack); chk("R9 address after mid-byte START", ack, 0);
    exp_ptr = 8'h50;
    read_seq(1, "R9 no write after START abort");
    i2c_stop();

    // write across 0xFF
    i2c_start();
    send_byte(8'h72, ack);
    send_byte(8'hFE, ack);
    send_byte(8'h11, ack); chk("R3 ACK at 0xFE", ack, 0);
    send_byte(8'h22, ack); chk("R3 ACK at 0xFF", ack, 0);
    i2c_stop();
    exp_mem[8'hFE] = 8'h11;
    exp_mem[8'hFF] = 8'h22;
    chk("R7 pointer wraps on write", reg_addr, 0);
    exp_ptr = 0;
    i2c_start();
    send_byte(8'h73, ack);
    read_seq(1, "R7 read after write wrap");
    i2c_stop();
    i2c_start();
    send_byte(8'h72, ack);
    send_byte(8'hFE, ack);
    i2c_start();
    send_byte(8'h73, ack);
    exp_ptr = 8'hFE;
    read_seq(2, "R3 written bytes read back");
    i2c_stop();

    chk("R8 SDA drive changed while SCL high", r8_bad, 0);

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule